// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address by picking one of four 16-bit segment registers (code, data, stack, extra), moving its value up by four bit positions so that every segment starts on a 16-byte paragraph, and adding the offset. The segment is chosen from the kind of access being made. Instruction fetches use the code segment. Stack accesses use the stack segment. Ordinary data accesses use the data segment. String-destination accesses use the extra segment. For data and stack accesses, a valid override input can name a different segment register.

Besides the physical address, the block reports the first and the last byte address of the selected 64 KB segment. All three outputs are registered, so they appear one clock after the request is presented. The segment registers are loaded through a simple write port. A load takes effect for requests presented from the next cycle on.

Top module: `seg_addr_unit`

## Requirements
- R1: One cycle after a request, `phys_addr` equals `seg_base` plus the zero-extended `offset` of that request, reduced modulo 2^20.
- R2: `seg_base` is the selected 16-bit segment value followed by four zero bits, so its low four bits are always zero.
- R3: `seg_last` equals `seg_base` plus FFFFh, modulo 2^20.
- R4: With no override, the access type selects the segment register as follows: 0 (fetch) selects code, 1 (stack) selects stack, 2 (data) selects data, and 3 (string destination) selects extra.
- R5: When `ovr_valid` is high on a stack or data access, the segment named by `ovr_sel` is used instead. The encoding is 0 code, 1 data, 2 stack, 3 extra.
- R6: `ovr_valid` and `ovr_sel` have no effect on fetch or string-destination accesses.
- R7: When `wr_en` is high at a clock edge, `wr_val` is loaded into the register named by `wr_sel` (same encoding as R5). Requests presented in the following cycle see the new value, and the other registers keep their values.
- R8: A synchronous reset sets the code segment to FFFFh and the other three segments to 0, and forces all three outputs to zero. After reset, a fetch at offset 0 yields FFFF0h.
- R9: Sums above FFFFFh wrap around. For example, segment FFFFh with offset 0010h gives physical address 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register load strobe |
| wr_sel | input | 2 | Segment register to load (0 code, 1 data, 2 stack, 3 extra) |
| wr_val | input | 16 | Value to load |
| acc_type | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment (same encoding as wr_sel) |
| offset | input | 16 | Offset within the segment |
| phys_addr | output | 20 | Registered physical byte address |
| seg_base | output | 20 | Registered first address of the selected segment |
| seg_last | output | 20 | Registered last address of the selected segment |

## Verification
The assertions assume that reset is held for at least one clock before the first request. They also assume that `acc_type`, `offset` and `wr_en` are driven to known values, so that the previous-cycle comparisons are meaningful. The fetch-stability property further assumes that no write happens between the two fetch requests it compares. The bench meets these assumptions by holding reset for several cycles and by driving every input, including the override pins, on falling edges. It mixes random writes and requests, with random override values on every access type, with the three worked examples, the wrap case and the reset values.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NSEG  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_DEST  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int          SEG_W    = 16,
  parameter logic [15:0] CODE_RST = 16'hFFFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [SEG_W-1:0]      wr_val,
  output logic [NSEG*SEG_W-1:0] seg_flat
);
  // One register per segment; the code segment has its own reset value.
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL =
      (i == int'(SEG_CODE)) ? SEG_W'(CODE_RST) : '0;
    logic [SEG_W-1:0] seg_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q <= RST_VAL;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        seg_q <= wr_val;
      end
    end

    assign seg_flat[i*SEG_W +: SEG_W] = seg_q;
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [NSEG*SEG_W-1:0] seg_flat,
  input  logic [1:0]            acc_type,
  input  logic                  ovr_valid,
  input  logic [SEL_W-1:0]      ovr_sel,
  output logic [SEG_W-1:0]      seg_val
);
  logic [SEL_W-1:0] idx;

  // Default segment per access kind; the override only reaches stack and data.
  always_comb begin
    unique case (acc_t'(acc_type))
      ACC_FETCH: idx = SEG_CODE;
      ACC_STACK: idx = ovr_valid ? ovr_sel : SEG_STACK;
      ACC_DATA:  idx = ovr_valid ? ovr_sel : SEG_DATA;
      ACC_DEST:  idx = SEG_EXTRA;
      default:   idx = SEG_DATA;
    endcase
  end

  assign seg_val = seg_flat[idx*SEG_W +: SEG_W];
endmodule

// File: rtl/addr_form.sv
module addr_form #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] phys,
  output logic [ADDR_W-1:0] last
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'({OFF_W{1'b1}});

  // Paragraph alignment: low SHIFT bits of the base are zero.
  assign base = ADDR_W'({seg_val, {SHIFT{1'b0}}});
  // Both sums are truncated to ADDR_W bits, so they wrap modulo 2^ADDR_W.
  assign phys = base + ADDR_W'(offset);
  assign last = base + SPAN;
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int          SEG_W    = 16,
  parameter int          OFF_W    = 16,
  parameter int          SHIFT    = 4,
  parameter logic [15:0] CODE_RST = 16'hFFFF,
  localparam int         ADDR_W   = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [SEG_W-1:0]  wr_val,
  input  logic [1:0]        acc_type,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_sel,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [ADDR_W-1:0] seg_base,
  output logic [ADDR_W-1:0] seg_last
);
  logic [NSEG*SEG_W-1:0] seg_flat;
  logic [SEG_W-1:0]      seg_val;
  logic [ADDR_W-1:0]     base_c, phys_c, last_c;

  seg_regfile #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_val   (wr_val),
    .seg_flat (seg_flat)
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .seg_flat  (seg_flat),
    .acc_type  (acc_type),
    .ovr_valid (ovr_valid),
    .ovr_sel   (ovr_sel),
    .seg_val   (seg_val)
  );

  addr_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_form (
    .seg_val (seg_val),
    .offset  (offset),
    .base    (base_c),
    .phys    (phys_c),
    .last    (last_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      seg_base  <= '0;
      seg_last  <= '0;
    end else begin
      phys_addr <= phys_c;
      seg_base  <= base_c;
      seg_last  <= last_c;
    end
  end
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        acc_type,
  input logic [OFF_W-1:0]  offset,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [ADDR_W-1:0] seg_base,
  input logic [ADDR_W-1:0] seg_last
);
  AST_PHYS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phys_addr == seg_base + ADDR_W'($past(offset)))); // R1

  AST_PARAGRAPH: assert property (@(posedge clk)
    seg_base[SHIFT-1:0] == '0); // R2

  AST_LAST_SPAN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (seg_last == seg_base + ADDR_W'({OFF_W{1'b1}}))); // R3

  AST_FETCH_NO_OVR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc_type == 2'd0 && $past(acc_type) == 2'd0 && !$past(wr_en))
      |=> $stable(seg_base)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (phys_addr == '0 && seg_base == '0 && seg_last == '0)); // R8
endmodule

bind seg_addr_unit seg_addr_unit_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/seg_addr_unit_test.sv
module seg_addr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_val = '0;
  logic [1:0]  acc_type = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] offset = '0;
  logic [19:0] phys_addr, seg_base, seg_last;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_seg [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_unit uut (.*);

  function automatic logic [1:0] exp_idx(logic [1:0] acc, logic ov, logic [1:0] os);
    case (acc)
      2'd0:    return 2'd0;
      2'd1:    return ov ? os : 2'd2;
      2'd2:    return ov ? os : 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [19:0] exp_base(logic [15:0] s);
    return {s, 4'h0};
  endfunction

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic req(string tag, logic [1:0] acc, logic ov, logic [1:0] os,
                     logic [15:0] off);
    logic [19:0] b;
    b = exp_base(m_seg[exp_idx(acc, ov, os)]);
    acc_type = acc; ovr_valid = ov; ovr_sel = os; offset = off;
    @(negedge clk);
    check(tag, phys_addr, b + {4'h0, off});
    check("R2", seg_base, b);
    check("R3", seg_last, b + 20'h0FFFF);
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_val = val;
    @(negedge clk);
    m_seg[sel] = val;
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EA1));
    m_seg[0] = 16'hFFFF; m_seg[1] = '0; m_seg[2] = '0; m_seg[3] = '0;
    repeat (3) @(negedge clk);
    check("R8", phys_addr, 20'h0);
    check("R8", seg_base, 20'h0);
    rst = 1'b0;
    // R8: reset values of the segments
    req("R8", 2'd0, 1'b0, 2'd0, 16'h0000);
    check("R8", seg_base, 20'hFFFF0);
    req("R8", 2'd2, 1'b0, 2'd0, 16'h0000);
    // R9: wrap past FFFFFh
    req("R9", 2'd0, 1'b0, 2'd0, 16'h0010);
    check("R9", phys_addr, 20'h00000);
    // R7 / R1: worked examples
    wr(2'd1, 16'h1000);
    req("R7", 2'd2, 1'b0, 2'd0, 16'h2000);
    check("R1", phys_addr, 20'h12000);
    wr(2'd0, 16'h348A);
    req("R1", 2'd0, 1'b0, 2'd0, 16'h4214);
    check("R1", phys_addr, 20'h38AB4);
    wr(2'd2, 16'h1200);
    req("R4", 2'd1, 1'b0, 2'd0, 16'hFFF0);
    check("R4", phys_addr, 20'h21FF0);
    wr(2'd3, 16'hAAF0);
    req("R4", 2'd3, 1'b0, 2'd0, 16'h0134);
    check("R4", phys_addr, 20'hAB034);
    // R5: override on data and stack
    req("R5", 2'd2, 1'b1, 2'd3, 16'h0001);
    check("R5", seg_base, 20'hAAF00);
    req("R5", 2'd1, 1'b1, 2'd0, 16'h0002);
    check("R5", seg_base, 20'h348A0);
    // R6: override ignored on fetch and destination
    req("R6", 2'd0, 1'b1, 2'd1, 16'h0003);
    check("R6", seg_base, 20'h348A0);
    req("R6", 2'd3, 1'b1, 2'd2, 16'h0004);
    check("R6", seg_base, 20'hAAF00);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0)
        wr(2'($urandom_range(0, 3)), 16'($urandom));
      else
        req("R1", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule